// File: doc/BRIEF.md
# DRAM Refresh Scheduler (CAS-before-RAS)

This block keeps an asynchronous DRAM's contents alive by issuing CAS-before-RAS refresh cycles at a steady rate. A free-running interval timer works out its period from the system clock frequency, the retention time and the number of rows. It adds one refresh to an "owed" count every period. Whenever refreshes are owed, the block raises a request to the access sequencer. Once the sequencer grants the bus, the block drives the row and column strobes through a complete refresh cycle. The DRAM steps its own internal row counter on each such cycle, so the block never drives an address.

Long page-mode bursts can hold the bus for more than one period. While that happens, missed periods pile up in a saturating owed counter. When the grant finally arrives, the block runs refresh cycles back to back until the count reaches zero, and only then releases the request. If a period expires while the count is already full, that refresh is lost. The block then raises a sticky error flag that only reset clears.

Top module: `dram_refresh_sched`

## Requirements
- R1: After a synchronous active-low reset, `ras_n`, every `cas_n` lane and `we_n` are high, `rfsh_req` is low, `owed` is 0 and `backlog_err` is low.
- R2: One refresh is added to `owed` every INTERVAL clocks, where INTERVAL = floor(CLK_KHZ*RETENTION_US/(1000*ROWS)). This is 2001 with the defaults. Any window of k*INTERVAL consecutive clocks therefore adds exactly k.
- R3: `rfsh_req` is high exactly when `owed` is nonzero or a refresh cycle is in progress. A refresh cycle starts only on a clock where `rfsh_req` and `rfsh_gnt` are both high. Without a grant, the strobes stay idle.
- R4: In each refresh cycle, CAS goes low CSR_CYC clocks before RAS falls. RAS then stays low for RAS_CYC clocks. RAS is never low while CAS is high.
- R5: CAS stays low for HOLD_CYC clocks after RAS rises. After that, both strobes stay high for at least RP_CYC clocks before the next cycle.
- R6: `we_n` is high at all times.
- R7: `owed` drops by one on the clock at which CAS is released. While `rfsh_gnt` stays high and `owed` is nonzero, the next cycle starts directly after the precharge clocks.
- R8: `owed` saturates at BACKLOG_MAX (8).
- R9: If a period expires while `owed` equals BACKLOG_MAX and no cycle completes on that clock, `backlog_err` goes high. It then stays high until reset.
- R10: All `cas_n` lanes carry the same value on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rfsh_gnt | input | 1 | Bus grant from the access sequencer |
| rfsh_req | output | 1 | Bus request to the access sequencer |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | CAS_LANES | Column strobes, one per byte lane, active low |
| we_n | output | 1 | Write enable, held high |
| owed | output | $clog2(BACKLOG_MAX+1) | Refreshes currently owed |
| backlog_err | output | 1 | Sticky flag: a refresh was lost to a full backlog |

## Verification
The assertions take for granted that the sequencer follows a four-phase handshake. It raises `rfsh_gnt` only while `rfsh_req` is high and never withdraws it before `rfsh_req` falls. That rule is what lets a cycle completion arrive only when something is owed. The bench sequencer models this directly: in the free state it echoes `rfsh_req` one clock later as the grant. It enters the busy state only on a clock where `rfsh_req` is low, so a grant is never pulled from under a running refresh. The busy windows are whole multiples of the interval, which makes the owed count at the end of each window known in advance.

// File: rtl/dram_rfsh_pkg.sv
// Package dram_rfsh_pkg
// Shared state encoding and a small helper for the refresh scheduler.
// Assumes nothing beyond the IEEE 1800-2017 language.
package dram_rfsh_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_ACTIVE = 3'd2,
        ST_HOLD   = 3'd3,
        ST_PRECH  = 3'd4
    } rfsh_state_e;

    // Largest of four phase lengths, used to size the phase counter.
    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
// Module rfsh_interval_timer
// Emits a one-clock tick every INTERVAL clocks. The count runs down to zero
// and then reloads. Assumes INTERVAL >= 2.
module rfsh_interval_timer #(
    parameter int unsigned INTERVAL = 2001
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned TW = $clog2(INTERVAL + 1);

    logic [TW-1:0] remain;

    // Down-counter that reloads after reaching zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= TW'(INTERVAL - 1);
        end else if (remain == '0) begin
            remain <= TW'(INTERVAL - 1);
        end else begin
            remain <= remain - 1'b1;
        end
    end

    assign tick = (remain == '0);

    // The count never exceeds the reload value (R2).
    assert_timer_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        remain <= TW'(INTERVAL - 1));

endmodule

// File: rtl/rfsh_backlog.sv
// Module rfsh_backlog
// Keeps the number of refreshes owed. Each tick adds one and each completed
// cycle removes one. The count saturates at MAX_OWED, and a tick that finds
// it full sets a sticky error. Assumes done is raised only while the count
// is nonzero.
module rfsh_backlog #(
    parameter int unsigned MAX_OWED = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            tick,
    input  logic                            done,
    output logic [$clog2(MAX_OWED+1)-1:0]   owed,
    output logic                            lost
);
    localparam int unsigned OW = $clog2(MAX_OWED + 1);

    // Owed counter: up on tick, down on completion, net zero on both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owed <= '0;
        end else begin
            unique case ({tick, done})
                2'b10:   if (owed != OW'(MAX_OWED)) owed <= owed + 1'b1;
                2'b01:   owed <= owed - 1'b1;
                default: owed <= owed;
            endcase
        end
    end

    // Sticky loss flag: a tick arrived with no room left.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lost <= 1'b0;
        end else if (tick && !done && (owed == OW'(MAX_OWED))) begin
            lost <= 1'b1;
        end
    end

    assert_owed_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        owed <= OW'(MAX_OWED));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lost |=> lost);

    assert_done_needs_owed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (owed != '0));

endmodule

// File: rtl/rfsh_strobe_fsm.sv
// Module rfsh_strobe_fsm
// Sequences one CAS-before-RAS cycle through four phases: CAS setup, RAS
// low, CAS hold after RAS rises, and precharge. At the end of precharge it
// chains into another cycle if refreshes are still owed and the grant is
// still held. Assumes every phase length is >= 1 and that the grant is not
// withdrawn while the request is high.
module rfsh_strobe_fsm
    import dram_rfsh_pkg::*;
#(
    parameter int unsigned CSR_CYC  = 2,
    parameter int unsigned RAS_CYC  = 8,
    parameter int unsigned HOLD_CYC = 2,
    parameter int unsigned RP_CYC   = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gnt,
    input  logic owed_nz,
    output logic req,
    output logic ras_n,
    output logic cas_n,
    output logic done
);
    localparam int unsigned LONGEST = max4(CSR_CYC, RAS_CYC, HOLD_CYC, RP_CYC);
    localparam int unsigned CW      = $clog2(LONGEST + 1);

    rfsh_state_e   state;
    logic [CW-1:0] phase_left;
    logic          go;

    assign go = owed_nz && gnt;

    // Phase state and the cycles left in the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            phase_left <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (go) begin
                        state      <= ST_SETUP;
                        phase_left <= CW'(CSR_CYC - 1);
                    end
                end
                ST_SETUP: begin
                    if (phase_left == '0) begin
                        state      <= ST_ACTIVE;
                        phase_left <= CW'(RAS_CYC - 1);
                    end else begin
                        phase_left <= phase_left - 1'b1;
                    end
                end
                ST_ACTIVE: begin
                    if (phase_left == '0) begin
                        state      <= ST_HOLD;
                        phase_left <= CW'(HOLD_CYC - 1);
                    end else begin
                        phase_left <= phase_left - 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (phase_left == '0) begin
                        state      <= ST_PRECH;
                        phase_left <= CW'(RP_CYC - 1);
                    end else begin
                        phase_left <= phase_left - 1'b1;
                    end
                end
                ST_PRECH: begin
                    if (phase_left == '0) begin
                        state      <= go ? ST_SETUP : ST_IDLE;
                        phase_left <= go ? CW'(CSR_CYC - 1) : '0;
                    end else begin
                        phase_left <= phase_left - 1'b1;
                    end
                end
                default: begin
                    state      <= ST_IDLE;
                    phase_left <= '0;
                end
            endcase
        end
    end

    // Strobe and handshake decode from the registered state.
    always_comb begin
        ras_n = (state != ST_ACTIVE);
        cas_n = !((state == ST_SETUP) || (state == ST_ACTIVE) || (state == ST_HOLD));
        req   = owed_nz || (state != ST_IDLE);
        done  = (state == ST_HOLD) && (phase_left == '0);
    end

    assert_ras_needs_cas_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> !cas_n);

    assert_cas_leads_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $past(!cas_n));

    assert_cas_after_ras_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_n) |-> (ras_n && $past(ras_n)));

    assert_start_needs_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) && !gnt) |=> (state == ST_IDLE));

endmodule

// File: rtl/dram_refresh_sched.sv
// Module dram_refresh_sched
// Top of the refresh scheduler. Derives the refresh period from the clock
// rate and the retention budget, keeps the owed count, and runs
// CAS-before-RAS cycles on the DRAM strobes after a request/grant handshake
// with the access sequencer. Assumes the sequencer holds the grant until the
// request falls.
module dram_refresh_sched
    import dram_rfsh_pkg::*;
#(
    parameter int unsigned CLK_KHZ      = 125000,
    parameter int unsigned RETENTION_US = 16400,
    parameter int unsigned ROWS         = 1024,
    parameter int unsigned BACKLOG_MAX  = 8,
    parameter int unsigned CAS_LANES    = 2,
    parameter int unsigned CSR_CYC      = 2,
    parameter int unsigned RAS_CYC      = 8,
    parameter int unsigned HOLD_CYC     = 2,
    parameter int unsigned RP_CYC       = 6
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               rfsh_gnt,
    output logic                               rfsh_req,
    output logic                               ras_n,
    output logic [CAS_LANES-1:0]               cas_n,
    output logic                               we_n,
    output logic [$clog2(BACKLOG_MAX+1)-1:0]   owed,
    output logic                               backlog_err
);
    localparam longint unsigned PERIOD_NUM = longint'(CLK_KHZ) * longint'(RETENTION_US);
    localparam longint unsigned PERIOD_DEN = 64'd1000 * longint'(ROWS);
    localparam int unsigned     INTERVAL   = int'(PERIOD_NUM / PERIOD_DEN);

    logic tick;
    logic done;
    logic cas_any_n;

    rfsh_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    rfsh_backlog #(.MAX_OWED(BACKLOG_MAX)) u_backlog (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .done  (done),
        .owed  (owed),
        .lost  (backlog_err)
    );

    rfsh_strobe_fsm #(
        .CSR_CYC  (CSR_CYC),
        .RAS_CYC  (RAS_CYC),
        .HOLD_CYC (HOLD_CYC),
        .RP_CYC   (RP_CYC)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .gnt     (rfsh_gnt),
        .owed_nz (owed != '0),
        .req     (rfsh_req),
        .ras_n   (ras_n),
        .cas_n   (cas_any_n),
        .done    (done)
    );

    // Fan the single column strobe out to every byte lane.
    for (genvar g = 0; g < CAS_LANES; g++) begin : g_cas_lane
        assign cas_n[g] = cas_any_n;
    end

    // Write enable stays inactive: refresh never writes.
    assign we_n = 1'b1;

    assert_req_when_owed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (owed != '0) |-> rfsh_req);

    assert_owed_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(owed) == owed) || ($past(owed) + 1'b1 == owed) ||
                          ($past(owed) == owed + 1'b1)));

endmodule

// File: tb/dram_refresh_sched_tb.sv
module dram_refresh_sched_tb;
    localparam int CLK_KHZ = 125000, RET_US = 16400, ROWS = 1024;
    localparam int MAXO = 8, LANES = 2;
    localparam int CSR = 2, RASC = 8, HOLD = 2, RP = 6;
    localparam int INTV = int'((longint'(CLK_KHZ) * RET_US) / (longint'(1000) * ROWS));
    localparam int LCYC = CSR + RASC + HOLD + RP;

    logic clk = 1'b0, rst_n = 1'b0, rfsh_gnt = 1'b0;
    logic rfsh_req, ras_n, we_n, backlog_err;
    logic [LANES-1:0] cas_n;
    logic [$clog2(MAXO+1)-1:0] owed;

    int checks = 0, errors = 0, cycles = 0;
    bit bus_free = 1'b0, cmp_on = 1'b0;

    dram_refresh_sched u_dut (
        .clk(clk), .rst_n(rst_n), .rfsh_gnt(rfsh_gnt), .rfsh_req(rfsh_req),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .owed(owed),
        .backlog_err(backlog_err)
    );

    always #4 clk = ~clk;   // 125 MHz

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: timer, owed count, and a position in the cycle
    // timeline (-1 when idle).
    int m_tmr, m_owed, m_t;
    bit m_err;
    always @(posedge clk) begin
        bit tk, dn;
        int nt;
        if (!rst_n) begin
            m_tmr = INTV - 1; m_owed = 0; m_t = -1; m_err = 0;
        end else begin
            tk = (m_tmr == 0);
            dn = (m_t == CSR + RASC + HOLD - 1);
            if (m_t == -1 || m_t == LCYC - 1) nt = (m_owed != 0 && rfsh_gnt) ? 0 : -1;
            else nt = m_t + 1;
            if (tk && !dn) begin
                if (m_owed == MAXO) m_err = 1; else m_owed++;
            end else if (dn && !tk) m_owed--;
            m_tmr = tk ? INTV - 1 : m_tmr - 1;
            m_t = nt;
        end
    end

    // Sequencer model: echoes the request as the grant while the bus is free.
    always @(negedge clk) rfsh_gnt <= bus_free ? rfsh_req : 1'b0;

    // Per-clock comparison and strobe timing measurement.
    int cas_run = 0, ras_run = 0, hold_run = 0, gap_run = 100, ras_falls = 0;
    bit p_ras = 1, p_cas = 0, seen_ras = 0;
    always @(negedge clk) begin
        bit cl;
        if (cmp_on) begin
            cl = (cas_n == '0);
            chk(ras_n == !(m_t >= CSR && m_t < CSR + RASC), "R4 ras_n vs model", ras_n, !(m_t >= CSR && m_t < CSR + RASC));
            chk(cas_n[0] == !(m_t >= 0 && m_t < CSR + RASC + HOLD), "R5 cas_n vs model", cas_n[0], !(m_t >= 0 && m_t < CSR + RASC + HOLD));
            chk(rfsh_req == (m_owed != 0 || m_t != -1), "R3 req vs model", rfsh_req, (m_owed != 0 || m_t != -1));
            chk(int'(owed) == m_owed, "R7 owed vs model", owed, m_owed);
            chk(backlog_err == m_err, "R9 err vs model", backlog_err, m_err);
            chk(we_n == 1'b1, "R6 we_n high", we_n, 1);
            chk(cas_n == '0 || cas_n == '1, "R10 lanes equal", cas_n, cas_n[0] ? 3 : 0);
            if (p_ras && !ras_n) begin
                chk(cas_run == CSR, "R4 cas lead", cas_run, CSR);
                ras_falls++;
                seen_ras = 1;
            end
            if (!p_ras && ras_n) chk(ras_run == RASC, "R4 ras width", ras_run, RASC);
            if (p_cas && !cl) chk(hold_run == HOLD, "R5 cas hold", hold_run, HOLD);
            if (!p_cas && cl) chk(gap_run >= RP, "R5 precharge gap", gap_run, RP);
            cas_run  = cl ? cas_run + 1 : 0;
            ras_run  = !ras_n ? ras_run + 1 : 0;
            hold_run = (cl && ras_n && seen_ras) ? hold_run + 1 : 0;
            gap_run  = cl ? 0 : gap_run + 1;
            if (!cl) seen_ras = 0;
            p_ras = ras_n; p_cas = cl;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wait_clks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic go_busy();
        while (rfsh_req) @(negedge clk);
        bus_free = 1'b0;
    endtask

    task automatic drain();
        bus_free = 1'b1;
        @(negedge clk);
        while (rfsh_req) @(negedge clk);
        wait_clks(2);
    endtask

    initial begin
        int f0;
        wait_clks(4);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        // R1: reset state
        chk(ras_n && we_n && cas_n == '1, "R1 strobes idle", {ras_n, we_n}, 3);
        chk(!rfsh_req, "R1 req low", rfsh_req, 0);
        chk(owed == 0, "R1 owed zero", owed, 0);
        chk(!backlog_err, "R1 err low", backlog_err, 0);

        // Free bus: one refresh per interval.
        bus_free = 1'b1;
        f0 = ras_falls;
        wait_clks(3 * INTV);
        wait_clks(LCYC + 4);
        chk(ras_falls - f0 == 3, "R2 one refresh per interval", ras_falls - f0, 3);

        // Busy bus for three intervals: backlog then back-to-back drain.
        go_busy();
        f0 = ras_falls;
        wait_clks(3 * INTV);
        chk(owed == 3, "R2 three owed after three intervals", owed, 3);
        chk(ras_falls == f0, "R3 no cycle without grant", ras_falls - f0, 0);
        chk(rfsh_req, "R3 req held while owed", rfsh_req, 1);
        drain();
        chk(ras_falls - f0 == 3, "R7 back-to-back drain count", ras_falls - f0, 3);
        chk(owed == 0, "R7 owed empty after drain", owed, 0);
        chk(!backlog_err, "R9 no loss at three", backlog_err, 0);

        // Busy for ten intervals: saturation and sticky loss.
        go_busy();
        f0 = ras_falls;
        wait_clks(10 * INTV);
        chk(owed == MAXO, "R8 owed saturates", owed, MAXO);
        chk(backlog_err, "R9 loss flagged", backlog_err, 1);
        drain();
        chk(ras_falls - f0 == MAXO, "R7 drains saturated backlog", ras_falls - f0, MAXO);
        chk(backlog_err, "R9 err stays after drain", backlog_err, 1);

        // Reset clears the sticky flag.
        cmp_on = 1'b0;
        rst_n = 1'b0;
        wait_clks(3);
        rst_n = 1'b1;
        p_ras = 1; p_cas = 0; gap_run = 100; cas_run = 0; ras_run = 0; hold_run = 0;
        cmp_on = 1'b1;
        chk(!backlog_err, "R1 err cleared by reset", backlog_err, 0);
        chk(owed == 0 && !rfsh_req, "R1 owed and req after reset", owed, 0);
        wait_clks(INTV + LCYC + 4);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule